// File: doc/BRIEF.md
# Dual-Half Lookup Table with Memory Modes

This block models one logic cell built from two half lookup tables, named half A and half B. Each half holds a 32-bit table, and a mode register chooses how that table is used. In logic mode the half works as a 5-input function: the five inputs of the half select one bit of the table. In memory mode the same 32 bits act as a 16-word by 2-bit read/write store. Each half has its own 4-bit address, and its read data is combinational. Each half picks its mode independently of the other. A cell can therefore hold a small RAM in one half and a random logic function in the other.

A join setting turns the two halves into one 16-word by 4-bit memory. In this setting both halves are read and written at the address on the A inputs. Half A holds the upper two data bits and half B holds the lower two. Each half has its own write-enable pin, and a write-port enable shared by both halves gates both of them. A parallel load port sets the table and mode of one half, and the join setting, in a single clock cycle.

Two finite-state machines run the block. The first is the per-half mode machine, with states HM_LOGIC and HM_MEMORY. The transition HM_LOGIC→HM_MEMORY is taken on a load with the memory flag set. HM_MEMORY→HM_LOGIC is taken on a load with the flag clear. A load to the same mode keeps the state. The second is the join machine, with states JS_SPLIT and JS_JOINED. It takes JS_SPLIT→JS_JOINED on any load with the join flag set, and JS_JOINED→JS_SPLIT on any load with the flag clear. While the join machine is in JS_JOINED, both halves read and write as memories, whatever state their own mode machine holds.

Top module: `lut_cell`

## Requirements
- R1: After reset, both halves are in logic mode, the join setting is off, every table bit is zero, and f_out is 0 for every input value.
- R2: In logic mode a half outputs bit number x of its table, where x is the 5-bit value on its inputs (a_in for A, b_in for B). That bit is copied onto both of the half's output lines: f_out[3:2] for A and f_out[1:0] for B.
- R3: When cfg_load is high at a rising edge, three things happen. The half named by cfg_half (0 selects A, 1 selects B) takes cfg_table as its table and takes cfg_mem as its mode (1 means memory). The join setting takes cfg_join. No memory write happens in either half in that cycle.
- R4: In memory mode a half outputs the word at its 4-bit address k. Table bit 2k+1 drives the half's upper output line and bit 2k drives the lower line, so a table loaded through the load port becomes the initial memory contents.
- R5: The write strobe of half A is a_in[4] AND wpe, and that of half B is b_in[4] AND wpe. When the strobe is high in memory mode, the rising edge stores wd[3:2] (for A) or wd[1:0] (for B) at the half's address. The new word shows on f_out in the next cycle.
- R6: There is no write when wpe is low, when the half's write-enable pin is low, or when the half is in logic mode.
- R7: The mode, the writes and the inputs of one half never change the output or the contents of the other half.
- R8: With the join setting on, both halves act as memories. Both use a_in[3:0] as the address, and b_in[3:0] has no effect. The write enables stay a_in[4] for A and b_in[4] for B.
- R9: When the join setting is cleared, each half returns to the mode it last loaded, and its contents are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and loads occur on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 5 | Half A inputs: function select in logic mode, or address [3:0] and write enable [4] in memory mode |
| b_in | input | 5 | Half B inputs, used the same way as a_in |
| wd | input | 4 | Write data: [3:2] for half A, [1:0] for half B |
| wpe | input | 1 | Write-port enable shared by both halves |
| cfg_load | input | 1 | Parallel load strobe |
| cfg_half | input | 1 | Half targeted by a load (0 = A, 1 = B) |
| cfg_mem | input | 1 | Mode loaded into the target half (1 = memory) |
| cfg_join | input | 1 | Join setting loaded on every load |
| cfg_table | input | 32 | Table value loaded into the target half |
| f_out | output | 4 | Cell outputs: [3:2] from half A, [1:0] from half B |

## Verification
Read data and logic-mode results are combinational, so they are due in the same cycle as the inputs that select them. Writes and loads take effect at the next rising edge, and their results are first visible in the cycle after that edge. The bench drives each input vector just after a falling edge and compares f_out 1 ns later, before the rising edge. Its reference model of the tables, modes and join setting updates only at the rising edge. Every comparison therefore sees exactly the effects of the earlier edges and none from the edge still to come. The bench sweeps every function select and every address in each mode, and probes the blocked-write cases by reading back the affected words.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;

    // Address bits of one half in memory mode
    localparam int ADDR_W   = 4;
    // Bits per memory word of one half
    localparam int WORD_W   = 2;
    // Number of halves in a cell
    localparam int NUM_HALF = 2;
    // Inputs per half (address plus write enable in memory mode)
    localparam int SEL_W    = ADDR_W + 1;
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int TBL_W    = DEPTH * WORD_W;
    localparam int IDX_W    = $clog2(TBL_W);
    localparam int OUT_W    = NUM_HALF * WORD_W;

    typedef enum logic {
        HM_LOGIC  = 1'b0,
        HM_MEMORY = 1'b1
    } half_mode_e;

    typedef enum logic {
        JS_SPLIT  = 1'b0,
        JS_JOINED = 1'b1
    } join_state_e;

    typedef logic [TBL_W-1:0]  table_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [SEL_W-1:0]  sel_t;

endpackage

// File: rtl/lut_join_ctrl.sv
module lut_join_ctrl
    import lut_cell_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_load,
    input  logic cfg_join,
    output logic joined
);

    join_state_e state_q;
    join_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= JS_SPLIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: a load with the join flag set enters the joined state,
    // a load with the flag clear leaves it
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            JS_SPLIT: begin
                if (cfg_load && cfg_join) begin
                    state_d = JS_JOINED;
                end
            end
            JS_JOINED: begin
                if (cfg_load && !cfg_join) begin
                    state_d = JS_SPLIT;
                end
            end
            default: state_d = JS_SPLIT;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            JS_JOINED: joined = 1'b1;
            default:   joined = 1'b0;
        endcase
    end

endmodule

// File: rtl/lut_wr_steer.sv
module lut_wr_steer
    import lut_cell_pkg::*;
(
    input  sel_t                a_in,
    input  sel_t                b_in,
    input  logic                wpe,
    input  logic                cfg_load,
    input  logic                joined,
    input  logic [NUM_HALF-1:0] half_mem,
    output logic [NUM_HALF-1:0] half_we,
    output addr_t               half_addr [NUM_HALF]
);

    logic [NUM_HALF-1:0] pin_we;
    addr_t               own_addr [NUM_HALF];

    assign pin_we[0]   = a_in[SEL_W-1];
    assign pin_we[1]   = b_in[SEL_W-1];
    assign own_addr[0] = a_in[ADDR_W-1:0];
    assign own_addr[1] = b_in[ADDR_W-1:0];

    // Half 0 always uses its own address. In joined mode every other half
    // follows the half-0 address.
    for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
        // Per-half enable pin ANDed with the shared port enable; a load
        // cycle suppresses every write
        assign half_we[h] = half_mem[h] & pin_we[h] & wpe & ~cfg_load;

        if (h == 0) begin : g_lead
            assign half_addr[h] = own_addr[h];
        end else begin : g_follow
            assign half_addr[h] = joined ? own_addr[0] : own_addr[h];
        end
    end

endmodule

// File: rtl/lut_half_table.sv
module lut_half_table
    import lut_cell_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cfg_ld,
    input  logic   cfg_mem,
    input  table_t cfg_tbl,
    input  logic   force_mem,
    input  sel_t   sel_in,
    input  addr_t  addr,
    input  logic   wr_en,
    input  word_t  wr_data,
    output word_t  dout,
    output logic   is_mem
);

    half_mode_e mode_q;
    half_mode_e mode_d;
    half_mode_e eff_mode;
    table_t     tbl_q;
    logic [IDX_W-1:0] base;
    word_t      mem_word;

    // Mode state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= HM_LOGIC;
        end else begin
            mode_q <= mode_d;
        end
    end

    // Mode transitions, taken only on a load aimed at this half
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            HM_LOGIC: begin
                if (cfg_ld && cfg_mem) begin
                    mode_d = HM_MEMORY;
                end
            end
            HM_MEMORY: begin
                if (cfg_ld && !cfg_mem) begin
                    mode_d = HM_LOGIC;
                end
            end
            default: mode_d = HM_LOGIC;
        endcase
    end

    // Joining overrides the stored mode without changing it
    assign eff_mode = force_mem ? HM_MEMORY : mode_q;
    assign base     = IDX_W'(int'(addr) * WORD_W);

    // Table storage: the load port has priority, then memory writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else if (cfg_ld) begin
            tbl_q <= cfg_tbl;
        end else if (wr_en) begin
            for (int k = 0; k < WORD_W; k++) begin
                tbl_q[base + IDX_W'(k)] <= wr_data[k];
            end
        end
    end

    always_comb begin
        for (int k = 0; k < WORD_W; k++) begin
            mem_word[k] = tbl_q[base + IDX_W'(k)];
        end
    end

    // Outputs
    always_comb begin
        unique case (eff_mode)
            HM_MEMORY: begin
                dout   = mem_word;
                is_mem = 1'b1;
            end
            default: begin
                dout   = {WORD_W{tbl_q[IDX_W'(sel_in)]}};
                is_mem = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lut_cell.sv
module lut_cell
    import lut_cell_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] a_in,
    input  logic [SEL_W-1:0] b_in,
    input  logic [OUT_W-1:0] wd,
    input  logic             wpe,
    input  logic             cfg_load,
    input  logic             cfg_half,
    input  logic             cfg_mem,
    input  logic             cfg_join,
    input  logic [TBL_W-1:0] cfg_table,
    output logic [OUT_W-1:0] f_out
);

    logic                joined;
    logic [NUM_HALF-1:0] half_mem;
    logic [NUM_HALF-1:0] half_we;
    addr_t               half_addr [NUM_HALF];
    sel_t                half_sel  [NUM_HALF];
    logic                mem_a;
    logic                mem_b;

    assign half_sel[0] = a_in;
    assign half_sel[1] = b_in;
    assign mem_a       = half_mem[0];
    assign mem_b       = half_mem[1];

    lut_join_ctrl u_join (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_load),
        .cfg_join (cfg_join),
        .joined   (joined)
    );

    lut_wr_steer u_steer (
        .a_in      (a_in),
        .b_in      (b_in),
        .wpe       (wpe),
        .cfg_load  (cfg_load),
        .joined    (joined),
        .half_mem  (half_mem),
        .half_we   (half_we),
        .half_addr (half_addr)
    );

    // Half 0 (A) owns the upper data and output lines
    for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
        localparam int LANE = (NUM_HALF - 1 - h) * WORD_W;

        lut_half_table u_tbl (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_ld    (cfg_load && (int'(cfg_half) == h)),
            .cfg_mem   (cfg_mem),
            .cfg_tbl   (cfg_table),
            .force_mem (joined),
            .sel_in    (half_sel[h]),
            .addr      (half_addr[h]),
            .wr_en     (half_we[h]),
            .wr_data   (wd[LANE +: WORD_W]),
            .dout      (f_out[LANE +: WORD_W]),
            .is_mem    (half_mem[h])
        );
    end

endmodule

// File: rtl/lut_cell_chk.sv
module lut_cell_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] a_in,
    input logic [4:0] b_in,
    input logic [3:0] wd,
    input logic       wpe,
    input logic       cfg_load,
    input logic [3:0] f_out,
    input logic       half_a_mem,
    input logic       half_b_mem,
    input logic       join_on
);

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (f_out == 4'h0));

    // R2
    logic_dup_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !half_a_mem |-> (f_out[3] == f_out[2]));

    // R2
    logic_dup_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !half_b_mem |-> (f_out[1] == f_out[0]));

    // R5
    write_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (half_a_mem && a_in[4] && wpe && !cfg_load) |=>
        (a_in[3:0] != $past(a_in[3:0])) || (f_out[3:2] == $past(wd[3:2])));

    // R6
    hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (half_a_mem && !(a_in[4] && wpe) && !cfg_load) |=>
        (a_in[3:0] != $past(a_in[3:0])) || $stable(f_out[3:2]));

    // R8
    join_b_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (join_on && b_in[4] && wpe && !cfg_load) |=>
        (a_in[3:0] != $past(a_in[3:0])) || (f_out[1:0] == $past(wd[1:0])));

endmodule

bind lut_cell lut_cell_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_in       (a_in),
    .b_in       (b_in),
    .wd         (wd),
    .wpe        (wpe),
    .cfg_load   (cfg_load),
    .f_out      (f_out),
    .half_a_mem (mem_a),
    .half_b_mem (mem_b),
    .join_on    (joined)
);

// File: tb/lut_cell_tb.sv
module lut_cell_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  a_in = '0;
    logic [4:0]  b_in = '0;
    logic [3:0]  wd = '0;
    logic        wpe = 1'b0;
    logic        cfg_load = 1'b0;
    logic        cfg_half = 1'b0;
    logic        cfg_mem = 1'b0;
    logic        cfg_join = 1'b0;
    logic [31:0] cfg_table = '0;
    logic [3:0]  f_out;

    int checks = 0;
    int errors = 0;

    // Reference model
    logic [31:0] m_tbl [2];
    logic        m_mode [2];
    logic        m_join;
    logic [31:0] rng = 32'h1234_5678;

    always #2 clk = ~clk;

    lut_cell dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_in      (a_in),
        .b_in      (b_in),
        .wd        (wd),
        .wpe       (wpe),
        .cfg_load  (cfg_load),
        .cfg_half  (cfg_half),
        .cfg_mem   (cfg_mem),
        .cfg_join  (cfg_join),
        .cfg_table (cfg_table),
        .f_out     (f_out)
    );

    function automatic logic [31:0] rnd();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    function automatic logic [3:0] expect_f();
        logic [3:0] r;
        logic [3:0] ab;
        ab = m_join ? a_in[3:0] : b_in[3:0];
        if (m_mode[0] || m_join)
            r[3:2] = {m_tbl[0][{a_in[3:0], 1'b1}], m_tbl[0][{a_in[3:0], 1'b0}]};
        else
            r[3:2] = {2{m_tbl[0][a_in]}};
        if (m_mode[1] || m_join)
            r[1:0] = {m_tbl[1][{ab, 1'b1}], m_tbl[1][{ab, 1'b0}]};
        else
            r[1:0] = {2{m_tbl[1][b_in]}};
        return r;
    endfunction

    // Check before the edge, then apply the edge to the model
    task automatic tick(input string tag);
        logic [3:0] exp_v;
        logic [3:0] ab;
        #1;
        exp_v = expect_f();
        checks++;
        if (f_out !== exp_v) begin
            errors++;
            $display("FAIL %s: f_out=%h expected %h (a=%h b=%h)", tag, f_out, exp_v, a_in, b_in);
        end
        @(posedge clk);
        if (cfg_load) begin
            m_tbl[cfg_half]  = cfg_table;
            m_mode[cfg_half] = cfg_mem;
            m_join           = cfg_join;
        end else begin
            ab = m_join ? a_in[3:0] : b_in[3:0];
            if ((m_mode[0] || m_join) && a_in[4] && wpe) begin
                m_tbl[0][{a_in[3:0], 1'b1}] = wd[3];
                m_tbl[0][{a_in[3:0], 1'b0}] = wd[2];
            end
            if ((m_mode[1] || m_join) && b_in[4] && wpe) begin
                m_tbl[1][{ab, 1'b1}] = wd[1];
                m_tbl[1][{ab, 1'b0}] = wd[0];
            end
        end
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic load(input logic h, input logic mem, input logic jn,
                        input logic [31:0] t, input string tag);
        cfg_load  = 1'b1;
        cfg_half  = h;
        cfg_mem   = mem;
        cfg_join  = jn;
        cfg_table = t;
        tick(tag);
    endtask

    initial begin
        logic [31:0] r;
        m_tbl[0] = '0; m_tbl[1] = '0;
        m_mode[0] = 1'b0; m_mode[1] = 1'b0;
        m_join = 1'b0;
        repeat (3) @(negedge clk);
        // R1: asynchronous reset holds outputs at zero
        checks++;
        if (f_out !== 4'h0) begin
            errors++;
            $display("FAIL R1: f_out=%h expected 0 in reset", f_out);
        end
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            r = rnd(); a_in = r[4:0]; b_in = r[9:5]; wd = r[13:10]; wpe = 1'b0;
            tick("R1");
        end

        // R2, R6: logic mode in half A, write attempts ignored
        load(1'b0, 1'b0, 1'b0, 32'hA5C3_0F96, "R3");
        for (int i = 0; i < 32; i++) begin
            r = rnd(); a_in = 5'(i); b_in = r[4:0]; wd = r[8:5]; wpe = 1'b1;
            tick("R2");
        end
        load(1'b1, 1'b0, 1'b0, 32'h8000_7FF1, "R3");
        for (int i = 0; i < 32; i++) begin
            r = rnd(); b_in = 5'(i); a_in = r[4:0]; wd = r[8:5]; wpe = r[9];
            tick("R7");
        end
        for (int i = 0; i < 32; i++) begin
            a_in = 5'(i); b_in = 5'(31 - i); wpe = 1'b1;
            tick("R6");
        end

        // R4: half B as memory with loaded contents, A stays logic
        load(1'b1, 1'b1, 1'b0, 32'h3C96_E15A, "R3");
        for (int i = 0; i < 16; i++) begin
            r = rnd(); b_in = {1'b0, 4'(i)}; a_in = r[4:0]; wpe = 1'b1;
            tick("R4");
        end
        // R5: write all words, then read back
        for (int i = 0; i < 16; i++) begin
            r = rnd(); b_in = {1'b1, 4'(i)}; a_in = {1'b0, r[3:0]}; wd = r[7:4]; wpe = 1'b1;
            tick("R5");
        end
        for (int i = 0; i < 16; i++) begin
            b_in = {1'b0, 4'(i)}; wpe = 1'b0;
            tick("R5");
        end
        // R6: wpe low, then enable pin low
        for (int i = 0; i < 16; i++) begin
            r = rnd(); b_in = {1'b1, 4'(i)}; wd = r[3:0]; wpe = 1'b0;
            tick("R6");
        end
        for (int i = 0; i < 16; i++) begin
            r = rnd(); b_in = {1'b0, 4'(i)}; wd = r[3:0]; wpe = 1'b1;
            tick("R6");
        end
        for (int i = 0; i < 16; i++) begin
            b_in = {1'b0, 4'(i)}; wpe = 1'b0;
            tick("R6");
        end

        // R3: load coinciding with write strobes blocks the writes
        b_in = 5'b1_0101; a_in = 5'b1_0011; wd = 4'hF; wpe = 1'b1;
        load(1'b0, 1'b1, 1'b0, 32'h0F0F_5A5A, "R3");
        wpe = 1'b0;
        for (int i = 0; i < 16; i++) begin
            a_in = {1'b0, 4'(i)}; b_in = {1'b0, 4'(15 - i)};
            tick("R3");
        end

        // R7: both halves written at different addresses
        for (int i = 0; i < 16; i++) begin
            r = rnd(); a_in = {1'b1, 4'(i)}; b_in = {1'b1, 4'(i ^ 5)}; wd = r[3:0]; wpe = 1'b1;
            tick("R7");
        end
        for (int i = 0; i < 16; i++) begin
            a_in = {1'b0, 4'(i)}; b_in = {1'b0, 4'(i)}; wpe = 1'b0;
            tick("R7");
        end

        // R8: join, B stored as logic but forced to memory
        load(1'b1, 1'b0, 1'b1, 32'h6B2D_91E4, "R8");
        for (int i = 0; i < 16; i++) begin
            r = rnd(); a_in = {1'b1, 4'(i)}; b_in = {1'b1, r[3:0]}; wd = r[7:4]; wpe = 1'b1;
            tick("R8");
        end
        for (int i = 0; i < 16; i++) begin
            r = rnd(); a_in = {1'b0, 4'(i)}; b_in = {r[4], r[3:0]}; wpe = 1'b0;
            tick("R8");
        end
        for (int i = 0; i < 16; i++) begin
            r = rnd(); a_in = {1'b0, 4'(i)}; b_in = {1'b1, r[3:0]}; wd = r[7:4]; wpe = 1'b1;
            tick("R8");
        end
        for (int i = 0; i < 16; i++) begin
            r = rnd(); a_in = {1'b0, 4'(i)}; b_in = r[4:0]; wpe = 1'b0;
            tick("R8");
        end

        // R9: leave join, B returns to logic with its written contents
        load(1'b0, 1'b0, 1'b0, 32'hC001_D00D, "R9");
        for (int i = 0; i < 32; i++) begin
            r = rnd(); b_in = 5'(i); a_in = r[4:0]; wd = r[8:5]; wpe = 1'b1;
            tick("R9");
        end
        // R6: logic-mode writes in B left its contents untouched
        load(1'b0, 1'b1, 1'b1, 32'h1357_9BDF, "R8");
        for (int i = 0; i < 16; i++) begin
            r = rnd(); a_in = {1'b0, 4'(i)}; b_in = r[4:0]; wpe = 1'b0;
            tick("R6");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule